// File: doc/BRIEF.md
# Host/Engine Doorbell Mailbox

This block is a two-way message channel between a host processor and an embedded security engine. Each side has its own simple register port: a write strobe, an address, write data, and read data that follows the address in the same cycle. There are two independent directions, and each holds one message at a time. Host to engine: the host fills a 16-word input payload RAM and then writes a doorbell word. The engine reads the message and hands the slot back by setting the input-ready flag. Engine to host: the engine fills a 16-word output payload RAM and writes an output doorbell. The host reads the message and acknowledges it, which makes the output slot free again.

Each slot is guarded by a ready flag. While a slot is busy, the producer's doorbell writes and payload writes are discarded and a sticky error bit is set. The host has a status register with one bit per mailbox event: bit 0 for an output doorbell arriving and bit 1 for the input slot becoming free. The status bits are write-one-to-clear. A mask register sits beside the status register. The masked result drives an interrupt line, and the unmasked OR of the status bits drives a pending line.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset, both ready flags read 1, the host status and mask read 0, both error bits read 0, `h_irq` and `h_pending` are 0, and `e_msg_waiting` is 0.
- R2: While input ready is set, a host write to 0x100 + 4·k (k < 16) stores the word in input payload slot k. The engine reads it back at engine address 0x100 + 4·k, and the host reads it at the same host address.
- R3: A host write to 0x00 while input ready is set does three things in the next cycle: it stores the doorbell word (engine 0x00 and host 0x00), it clears input ready (host 0x08 bit 0), and it raises `e_msg_waiting`.
- R4: An engine write to engine 0x08 with bit 0 = 1 while input ready is clear sets input ready (host 0x08 bit 0 and engine 0x08 bit 0) and sets host status bit 1.
- R5: While output ready is set, engine writes to 0x200 + 4·k store output payload words, which the host reads at host 0x200 + 4·k. An engine write to engine 0x10 stores the output doorbell word (host 0x0C), clears output ready (engine 0x14 bit 0), and sets host status bit 0.
- R6: A host write to 0x0C with bit 0 = 1 while output ready is clear sets output ready again.
- R7: Host status (0x10) is write-one-to-clear. If a status event and a clear of the same bit happen in the same cycle, the bit ends up set.
- R8: Host mask (0x14, bits 1:0, same bit positions as the status bits): `h_irq` is 1 exactly when some status bit is 1 and its mask bit is 0.
- R9: `h_pending` is the OR of the two status bits, whatever the mask holds.
- R10: A host doorbell or input-payload write made while input ready is clear is dropped and sets the sticky host error flag (host 0x08 bit 1). Only reset clears it.
- R11: An engine doorbell or output-payload write made while output ready is clear is dropped and sets the sticky engine error flag (engine 0x14 bit 1). Only reset clears it.
- R12: Inside a payload window, word indices 16 to 63 (offsets 0x40 to 0xFF) read as zero, and writes to them change nothing. Host writes to the output window and engine writes to the input window are ignored. Unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| h_wr | input | 1 | Host write strobe |
| h_addr | input | 12 | Host byte address |
| h_wdata | input | DATA_W | Host write data |
| h_rdata | output | DATA_W | Host read data, combinational from `h_addr` |
| h_irq | output | 1 | Masked host interrupt |
| h_pending | output | 1 | OR of host status bits |
| e_wr | input | 1 | Engine write strobe |
| e_addr | input | 12 | Engine byte address |
| e_wdata | input | DATA_W | Engine write data |
| e_rdata | output | DATA_W | Engine read data, combinational from `e_addr` |
| e_msg_waiting | output | 1 | An input message is waiting for the engine |

## Verification
Directed sequences come first. They run one full round trip in each direction, send writes into busy slots, and make an engine release land in the same cycle as a host status clear. These separate the correct gating and set-over-clear priority from designs that let writes through or lose events. After that, a seeded random mix of host and engine writes covers every register, the in-range and out-of-range payload words, and the unmapped pages. It includes back-to-back writes on both ports in the same cycle. Comparing each read against an independent bench model exposes errors in the address decode, the mask polarity, and the ready and error flags that only appear in interleavings the directed cases do not reach.

// File: rtl/ipc_mbox_pkg.sv
// Package: address map and status bit positions shared by the mailbox modules.
package ipc_mbox_pkg;
    localparam int MB_ADDR_W = 12;

    // Host-side register offsets
    localparam logic [MB_ADDR_W-1:0] H_IN_DB   = 12'h000;
    localparam logic [MB_ADDR_W-1:0] H_IN_STS  = 12'h008;
    localparam logic [MB_ADDR_W-1:0] H_OUT_DB  = 12'h00C;
    localparam logic [MB_ADDR_W-1:0] H_INT_STS = 12'h010;
    localparam logic [MB_ADDR_W-1:0] H_INT_MSK = 12'h014;

    // Engine-side register offsets
    localparam logic [MB_ADDR_W-1:0] E_IN_DB   = 12'h000;
    localparam logic [MB_ADDR_W-1:0] E_IN_STS  = 12'h008;
    localparam logic [MB_ADDR_W-1:0] E_OUT_DB  = 12'h010;
    localparam logic [MB_ADDR_W-1:0] E_OUT_STS = 12'h014;

    // Payload windows (address bits 11:8), same on both ports
    localparam logic [3:0] IN_PAGE  = 4'h1;
    localparam logic [3:0] OUT_PAGE = 4'h2;

    // Host status / mask bit positions
    localparam int ST_OUT_DB = 0;
    localparam int ST_IN_RDY = 1;
endpackage

// File: rtl/mbox_payload_ram.sv
// Module: one payload buffer, with one write port and two combinational read ports.
// Assumes: WORDS is a power of two no larger than 64 (the size of a 256-byte window).
// Indices at or beyond WORDS read as zero and are ignored on write.
module mbox_payload_ram #(
    parameter int DATA_W = 32,
    parameter int WORDS  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [5:0]        wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [5:0]        rd_idx_a,
    output logic [DATA_W-1:0] rd_data_a,
    input  logic [5:0]        rd_idx_b,
    output logic [DATA_W-1:0] rd_data_b
);
    localparam int IW = (WORDS > 1) ? $clog2(WORDS) : 1;

    logic [DATA_W-1:0] mem [WORDS];

    // Storage: clear on reset, write only in-range words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '0;
        end else if (wr_en && (int'(wr_idx) < WORDS)) begin
            mem[wr_idx[IW-1:0]] <= wr_data;
        end
    end

    // Read ports: out-of-range indices return zero.
    always_comb begin
        rd_data_a = (int'(rd_idx_a) < WORDS) ? mem[rd_idx_a[IW-1:0]] : '0;
        rd_data_b = (int'(rd_idx_b) < WORDS) ? mem[rd_idx_b[IW-1:0]] : '0;
    end
endmodule

// File: rtl/mbox_dir_gate.sv
// Module: one-deep slot control for a single mailbox direction.
// Holds the ready flag, the doorbell word and a sticky protocol-error bit.
// Assumes: ring/pay_try come from the producer, release_i from the consumer.
module mbox_dir_gate #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ring,
    input  logic [DATA_W-1:0] ring_data,
    input  logic              pay_try,
    input  logic              release_i,
    output logic              rdy,
    output logic [DATA_W-1:0] db_value,
    output logic              err,
    output logic              ring_ok,
    output logic              pay_ok,
    output logic              raised
);
    // Accept strobes only while the slot is free; report a release that frees it.
    always_comb begin
        ring_ok = ring & rdy;
        pay_ok  = pay_try & rdy;
        raised  = release_i & ~rdy;
    end

    // Ready flag: cleared by an accepted doorbell, set by the consumer's release.
    always_ff @(posedge clk) begin
        if (!rst_n)        rdy <= 1'b1;
        else if (ring_ok)  rdy <= 1'b0;
        else if (raised)   rdy <= 1'b1;
    end

    // Doorbell word capture on an accepted ring.
    always_ff @(posedge clk) begin
        if (!rst_n)       db_value <= '0;
        else if (ring_ok) db_value <= ring_data;
    end

    // Sticky error when the producer writes into a busy slot.
    always_ff @(posedge clk) begin
        if (!rst_n)                          err <= 1'b0;
        else if ((ring | pay_try) && !rdy)   err <= 1'b1;
    end

    assert_ring_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ring && rdy) |=> !rdy);
    assert_rise_needs_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy) |-> $past(release_i));
    assert_busy_holds_db_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy |=> $stable(db_value));
    assert_drop_sets_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((ring || pay_try) && !rdy) |=> err);
    assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
endmodule

// File: rtl/mbox_irq.sv
// Module: host event status (write-one-to-clear) with mask, interrupt and pending.
// Assumes: set_i pulses for one cycle per event; a set wins over a clear in the same cycle.
module mbox_irq (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] set_i,
    input  logic       clr_wr,
    input  logic [1:0] clr_bits,
    input  logic       mask_wr,
    input  logic [1:0] mask_data,
    output logic [1:0] sts,
    output logic [1:0] mask,
    output logic       irq,
    output logic       pending
);
    // Status: clear the written ones, then OR in new events.
    always_ff @(posedge clk) begin
        if (!rst_n) sts <= '0;
        else        sts <= (sts & ~(clr_wr ? clr_bits : 2'b00)) | set_i;
    end

    // Mask register: a 1 suppresses the matching interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= '0;
        else if (mask_wr) mask <= mask_data;
    end

    // Outputs: masked interrupt and unmasked pending.
    always_comb begin
        irq     = |(sts & ~mask);
        pending = |sts;
    end

    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != 2'b00) |=> ((sts & $past(set_i)) == $past(set_i)));
    assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && set_i == 2'b00) |=> ((sts & $past(clr_bits)) == 2'b00));
endmodule

// File: rtl/ipc_mailbox.sv
// Module: host/engine doorbell mailbox, top level.
// Decodes both register ports, and instantiates two payload RAMs, two slot gates
// and the host interrupt block. Reads are combinational from the address.
// Assumes: DATA_W >= 2; PAY_WORDS is a power of two no larger than 64.
module ipc_mailbox
    import ipc_mbox_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int PAY_WORDS = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 h_wr,
    input  logic [MB_ADDR_W-1:0] h_addr,
    input  logic [DATA_W-1:0]    h_wdata,
    output logic [DATA_W-1:0]    h_rdata,
    output logic                 h_irq,
    output logic                 h_pending,
    input  logic                 e_wr,
    input  logic [MB_ADDR_W-1:0] e_addr,
    input  logic [DATA_W-1:0]    e_wdata,
    output logic [DATA_W-1:0]    e_rdata,
    output logic                 e_msg_waiting
);
    localparam int PAD = DATA_W - 2;

    logic h_in_win, h_out_win, e_in_win, e_out_win;
    logic in_rdy, in_err, in_ring_ok, in_pay_ok, in_raised;
    logic out_rdy, out_err, out_ring_ok, out_pay_ok, out_raised;
    logic [DATA_W-1:0] in_db, out_db;
    logic [DATA_W-1:0] in_rd_h, in_rd_e, out_rd_h, out_rd_e;
    logic [1:0] sts, mask;

    // Window decode for both ports.
    always_comb begin
        h_in_win  = (h_addr[11:8] == IN_PAGE);
        h_out_win = (h_addr[11:8] == OUT_PAGE);
        e_in_win  = (e_addr[11:8] == IN_PAGE);
        e_out_win = (e_addr[11:8] == OUT_PAGE);
    end

    mbox_dir_gate #(.DATA_W(DATA_W)) u_in_gate (
        .clk(clk), .rst_n(rst_n),
        .ring(h_wr && h_addr == H_IN_DB), .ring_data(h_wdata),
        .pay_try(h_wr && h_in_win),
        .release_i(e_wr && e_addr == E_IN_STS && e_wdata[0]),
        .rdy(in_rdy), .db_value(in_db), .err(in_err),
        .ring_ok(in_ring_ok), .pay_ok(in_pay_ok), .raised(in_raised)
    );

    mbox_dir_gate #(.DATA_W(DATA_W)) u_out_gate (
        .clk(clk), .rst_n(rst_n),
        .ring(e_wr && e_addr == E_OUT_DB), .ring_data(e_wdata),
        .pay_try(e_wr && e_out_win),
        .release_i(h_wr && h_addr == H_OUT_DB && h_wdata[0]),
        .rdy(out_rdy), .db_value(out_db), .err(out_err),
        .ring_ok(out_ring_ok), .pay_ok(out_pay_ok), .raised(out_raised)
    );

    mbox_payload_ram #(.DATA_W(DATA_W), .WORDS(PAY_WORDS)) u_in_ram (
        .clk(clk), .rst_n(rst_n),
        .wr_en(in_pay_ok), .wr_idx(h_addr[7:2]), .wr_data(h_wdata),
        .rd_idx_a(h_addr[7:2]), .rd_data_a(in_rd_h),
        .rd_idx_b(e_addr[7:2]), .rd_data_b(in_rd_e)
    );

    mbox_payload_ram #(.DATA_W(DATA_W), .WORDS(PAY_WORDS)) u_out_ram (
        .clk(clk), .rst_n(rst_n),
        .wr_en(out_pay_ok), .wr_idx(e_addr[7:2]), .wr_data(e_wdata),
        .rd_idx_a(h_addr[7:2]), .rd_data_a(out_rd_h),
        .rd_idx_b(e_addr[7:2]), .rd_data_b(out_rd_e)
    );

    mbox_irq u_irq (
        .clk(clk), .rst_n(rst_n),
        .set_i({in_raised, out_ring_ok}),
        .clr_wr(h_wr && h_addr == H_INT_STS), .clr_bits(h_wdata[1:0]),
        .mask_wr(h_wr && h_addr == H_INT_MSK), .mask_data(h_wdata[1:0]),
        .sts(sts), .mask(mask), .irq(h_irq), .pending(h_pending)
    );

    // Host read mux.
    always_comb begin
        h_rdata = '0;
        if (h_in_win)       h_rdata = in_rd_h;
        else if (h_out_win) h_rdata = out_rd_h;
        else begin
            case (h_addr)
                H_IN_DB:   h_rdata = in_db;
                H_IN_STS:  h_rdata = {{PAD{1'b0}}, in_err, in_rdy};
                H_OUT_DB:  h_rdata = out_db;
                H_INT_STS: h_rdata = {{PAD{1'b0}}, sts};
                H_INT_MSK: h_rdata = {{PAD{1'b0}}, mask};
                default:   h_rdata = '0;
            endcase
        end
    end

    // Engine read mux.
    always_comb begin
        e_rdata = '0;
        if (e_in_win)       e_rdata = in_rd_e;
        else if (e_out_win) e_rdata = out_rd_e;
        else begin
            case (e_addr)
                E_IN_DB:   e_rdata = in_db;
                E_IN_STS:  e_rdata = {{PAD{1'b0}}, 1'b0, in_rdy};
                E_OUT_DB:  e_rdata = out_db;
                E_OUT_STS: e_rdata = {{PAD{1'b0}}, out_err, out_rdy};
                default:   e_rdata = '0;
            endcase
        end
    end

    // Engine notification: a message sits in the input slot.
    assign e_msg_waiting = ~in_rdy;

    assert_out_ring_sets_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_ring_ok |=> (sts[ST_OUT_DB] && !out_rdy));
    assert_ack_frees_output_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_raised |=> out_rdy);
endmodule

// File: tb/ipc_mailbox_tb.sv
`timescale 1ns/1ps
module ipc_mailbox_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_wr = 1'b0, e_wr = 1'b0;
    logic [11:0] h_addr = '0, e_addr = '0;
    logic [31:0] h_wdata = '0, e_wdata = '0;
    logic [31:0] h_rdata, e_rdata;
    logic        h_irq, h_pending, e_msg_waiting;

    int checks = 0, errors = 0;
    bit done = 0;

    // Bench reference model
    logic [31:0] m_in_pay [16];
    logic [31:0] m_out_pay [16];
    logic [31:0] m_in_db, m_out_db;
    logic        m_in_rdy, m_out_rdy, m_herr, m_eerr;
    logic [1:0]  m_sts, m_mask;

    always #4 clk = ~clk;

    ipc_mailbox u_dut (
        .clk(clk), .rst_n(rst_n),
        .h_wr(h_wr), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
        .h_irq(h_irq), .h_pending(h_pending),
        .e_wr(e_wr), .e_addr(e_addr), .e_wdata(e_wdata), .e_rdata(e_rdata),
        .e_msg_waiting(e_msg_waiting)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] pay_exp(input logic [31:0] w, input logic [11:0] a);
        return w;
    endfunction

    function automatic logic [31:0] exp_h(input logic [11:0] a);
        if (a[11:8] == 4'h1) return (a[7:6] == 2'b00) ? m_in_pay[a[5:2]] : 32'h0;
        if (a[11:8] == 4'h2) return (a[7:6] == 2'b00) ? m_out_pay[a[5:2]] : 32'h0;
        case (a)
            12'h000: return m_in_db;
            12'h008: return {30'h0, m_herr, m_in_rdy};
            12'h00C: return m_out_db;
            12'h010: return {30'h0, m_sts};
            12'h014: return {30'h0, m_mask};
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] exp_e(input logic [11:0] a);
        if (a[11:8] == 4'h1) return (a[7:6] == 2'b00) ? m_in_pay[a[5:2]] : 32'h0;
        if (a[11:8] == 4'h2) return (a[7:6] == 2'b00) ? m_out_pay[a[5:2]] : 32'h0;
        case (a)
            12'h000: return m_in_db;
            12'h008: return {31'h0, m_in_rdy};
            12'h010: return m_out_db;
            12'h014: return {30'h0, m_eerr, m_out_rdy};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string req_h(input logic [11:0] a);
        if (a[11:8] == 4'h1 || a[11:8] == 4'h2) return (a[7:6] != 2'b00) ? "R12" : (a[11:8] == 4'h1 ? "R2" : "R5");
        case (a)
            12'h000: return "R3";
            12'h008: return "R10";
            12'h00C: return "R5";
            12'h010: return "R7";
            12'h014: return "R8";
            default: return "R12";
        endcase
    endfunction

    function automatic string req_e(input logic [11:0] a);
        if (a[11:8] == 4'h1 || a[11:8] == 4'h2) return (a[7:6] != 2'b00) ? "R12" : (a[11:8] == 4'h1 ? "R2" : "R5");
        case (a)
            12'h000: return "R3";
            12'h008: return "R4";
            12'h010: return "R5";
            12'h014: return "R11";
            default: return "R12";
        endcase
    endfunction

    // One clock with optional writes on both ports; the model follows the requirements.
    task automatic step(input logic hw, input logic [11:0] ha, input logic [31:0] hd,
                        input logic ew, input logic [11:0] ea, input logic [31:0] ed);
        logic nin, nout;
        logic [1:0] set, clr;
        @(negedge clk);
        h_wr = hw; h_addr = ha; h_wdata = hd;
        e_wr = ew; e_addr = ea; e_wdata = ed;
        @(posedge clk);
        nin = m_in_rdy; nout = m_out_rdy; set = 2'b00; clr = 2'b00;
        if (hw && (ha == 12'h000 || ha[11:8] == 4'h1)) begin
            if (m_in_rdy) begin
                if (ha == 12'h000) begin m_in_db = hd; nin = 1'b0; end
                else if (ha[7:6] == 2'b00) m_in_pay[ha[5:2]] = hd;
            end else m_herr = 1'b1;
        end
        if (ew && ea == 12'h008 && ed[0] && !m_in_rdy) begin nin = 1'b1; set[1] = 1'b1; end
        if (ew && (ea == 12'h010 || ea[11:8] == 4'h2)) begin
            if (m_out_rdy) begin
                if (ea == 12'h010) begin m_out_db = ed; nout = 1'b0; set[0] = 1'b1; end
                else if (ea[7:6] == 2'b00) m_out_pay[ea[5:2]] = ed;
            end else m_eerr = 1'b1;
        end
        if (hw && ha == 12'h00C && hd[0] && !m_out_rdy) nout = 1'b1;
        if (hw && ha == 12'h010) clr = hd[1:0];
        if (hw && ha == 12'h014) m_mask = hd[1:0];
        m_sts = (m_sts & ~clr) | set;
        m_in_rdy = nin; m_out_rdy = nout;
        #1;
        h_wr = 1'b0; e_wr = 1'b0;
    endtask

    task automatic hw_(input logic [11:0] a, input logic [31:0] d);
        step(1'b1, a, d, 1'b0, 12'h0, 32'h0);
    endtask

    task automatic ew_(input logic [11:0] a, input logic [31:0] d);
        step(1'b0, 12'h0, 32'h0, 1'b1, a, d);
    endtask

    // Read one address on each port and check all outputs against the model.
    task automatic look(input logic [11:0] ha, input logic [11:0] ea);
        @(negedge clk);
        h_addr = ha; e_addr = ea;
        #1;
        chk(req_h(ha), h_rdata, exp_h(ha));
        chk(req_e(ea), e_rdata, exp_e(ea));
        chk("R8", {31'h0, h_irq}, {31'h0, |(m_sts & ~m_mask)});
        chk("R9", {31'h0, h_pending}, {31'h0, |m_sts});
        chk("R3", {31'h0, e_msg_waiting}, {31'h0, ~m_in_rdy});
    endtask

    function automatic logic [11:0] pick();
        case ($urandom % 9)
            0: return 12'h000;
            1: return 12'h008;
            2: return 12'h00C;
            3: return 12'h010;
            4: return 12'h014;
            5: return 12'h100 + 12'(4 * ($urandom % 20));
            6: return 12'h200 + 12'(4 * ($urandom % 20));
            7: return 12'h300 + 12'(4 * ($urandom % 4));
            default: return 12'h004;
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7));
        for (int i = 0; i < 16; i++) begin m_in_pay[i] = '0; m_out_pay[i] = '0; end
        m_in_db = '0; m_out_db = '0; m_in_rdy = 1; m_out_rdy = 1;
        m_herr = 0; m_eerr = 0; m_sts = '0; m_mask = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        @(negedge clk); h_addr = 12'h008; e_addr = 12'h014; #1;
        chk("R1", h_rdata, 32'h1);
        chk("R1", e_rdata, 32'h1);
        chk("R1", {31'h0, h_irq}, 32'h0);
        chk("R1", {31'h0, h_pending}, 32'h0);
        chk("R1", {31'h0, e_msg_waiting}, 32'h0);
        h_addr = 12'h010; #1; chk("R1", h_rdata, 32'h0);

        // R2: fill the input payload, read it back from the engine
        for (int k = 0; k < 16; k++) hw_(12'h100 + 12'(4 * k), 32'hA5A5_0000 + 32'(k * 257));
        for (int k = 0; k < 16; k++) look(12'h100 + 12'(4 * k), 12'h100 + 12'(4 * k));

        // R12: beyond word 15 is ignored and reads zero
        hw_(12'h140, 32'hDEAD_BEEF);
        look(12'h140, 12'h17C);
        hw_(12'h200, 32'h1111_2222);
        look(12'h200, 12'h200);

        // R3: host doorbell
        hw_(12'h000, 32'h00C0_FFEE);
        look(12'h008, 12'h000);
        look(12'h000, 12'h008);

        // R10: writes into a busy input slot are dropped
        hw_(12'h104, 32'h5555_5555);
        hw_(12'h000, 32'h6666_6666);
        look(12'h104, 12'h000);
        look(12'h008, 12'h104);

        // R4 with R7: engine release in the same cycle as a host clear of bit 1
        step(1'b1, 12'h010, 32'h2, 1'b1, 12'h008, 32'h1);
        look(12'h010, 12'h008);
        hw_(12'h010, 32'h3);
        look(12'h010, 12'h008);

        // R5: engine output message
        for (int k = 0; k < 16; k++) ew_(12'h200 + 12'(4 * k), 32'h3C00_0000 ^ 32'(k * 4099));
        ew_(12'h010, 32'h0000_1234);
        for (int k = 0; k < 16; k += 5) look(12'h200 + 12'(4 * k), 12'h014);
        look(12'h00C, 12'h010);

        // R8 / R9: mask the output doorbell event
        hw_(12'h014, 32'h1);
        look(12'h014, 12'h014);
        hw_(12'h014, 32'h2);
        look(12'h010, 12'h014);

        // R11: engine writes into a busy output slot are dropped
        ew_(12'h010, 32'h9999_9999);
        ew_(12'h204, 32'h7777_7777);
        look(12'h00C, 12'h014);
        look(12'h204, 12'h010);

        // R6: host acknowledges the output
        hw_(12'h00C, 32'h0);
        look(12'h00C, 12'h014);
        hw_(12'h00C, 32'h1);
        look(12'h010, 12'h014);

        // Random mix on both ports
        for (int n = 0; n < 400; n++) begin
            logic [11:0] ha, ea;
            logic [31:0] hd, ed;
            ha = pick(); ea = pick();
            hd = $urandom; ed = $urandom;
            if ($urandom % 2 == 0) ed[0] = 1'b1;
            step(($urandom % 2) == 0, ha, hd, ($urandom % 2) == 0, ea, ed);
            look(pick(), pick());
        end

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule